// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block turns a 14-bit virtual address into a 12-bit physical address using a small cache of recently used page mappings. A page is 64 bytes, so the low six address bits are the offset inside the page. They go straight through to the physical address. The upper eight bits form the virtual page number. Its two low bits choose one of four sets. Its six high bits are the tag, which is compared against the four ways of that set. On a hit the stored 6-bit physical page number replaces the virtual page number.

A request strobe with an address gives a registered response one cycle later: a valid flag, hit or miss, and the physical address. A miss is the only signal handed to an external page-table walker. That walker later installs the mapping through the refill port. The refill picks its way in this order: a way already holding the same page, then the lowest free way, then a round-robin pointer kept per set. A flush input invalidates every entry in one cycle.

Top module: `tlb_xlate`

## Requirements
- R1: Bits 5:0 of the physical address in every response equal bits 5:0 of the requested virtual address.
- R2: The set index is VA bits 7:6 and the tag is VA bits 13:8. A lookup hits only when a valid way of the indexed set holds that tag. The hit places the stored page number in PA bits 11:6, so VA 0x03D4 with page 0x0F mapped to 0x0D returns PA 0x354.
- R3: A request gives a response exactly one cycle later, with exactly one of hit or miss set. On a miss, PA bits 11:6 are zero. In a cycle after no request, the valid, hit and miss outputs and the PA are all zero.
- R4: After reset, every entry is invalid and all outputs are zero, so the first lookup misses.
- R5: A flush invalidates all entries in one cycle and returns each set's round-robin pointer to way 0. A lookup in the same cycle as a flush misses. A refill in the same cycle as a flush is dropped.
- R6: A refill stores the mapping from a virtual page number to a physical page number, and later lookups of that page hit.
- R7: A refill fills the free ways of a set in order from way 0 upward. Once the set is full, it replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one only when it is used.
- R8: A refill of a page that is already present overwrites that way in place. It takes no free way and does not move the pointer.
- R9: When a refill and a lookup hit the same set in the same cycle, the lookup sees the entry being written.
- R10: A refill changes only the set it addresses. Entries in the other sets stay as they were.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup strobe |
| va_i | input | 14 | Virtual address to translate |
| fill_i | input | 1 | Refill strobe |
| fill_vpn_i | input | 8 | Virtual page number to install |
| fill_ppn_i | input | 6 | Physical page number to install |
| flush_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | Translation absent; request for a page walk |
| pa_o | output | 12 | Physical address |

## Verification
The hardest state to reach from the ports is a full set whose pointer has already moved. Only then do the replacement order and the in-place overwrite rule give different results. The stimulus flushes, fills four pages into set 0, and adds a fifth to push the pointer past way 0. It then rewrites a page already present, and a sixth refill must evict the second-oldest page. Any mix-up between overwrite, free-way and pointer selection shows up as a wrong hit or miss. The same-cycle refill and lookup case is driven on a single edge, and its result is checked on the following one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Which rule chose the way that a refill writes
   typedef enum logic [1:0] {
      VICT_MATCH  = 2'd0,
      VICT_FREE   = 2'd1,
      VICT_ROTATE = 2'd2
   } victim_src_e;

endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 6,
   parameter int PPN_W = 6
) (
   input  logic [WAYS-1:0]             valid_i,
   input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
   input  logic [WAYS-1:0][PPN_W-1:0]  ppn_i,
   input  logic [TAG_W-1:0]            key_i,
   output logic                        hit_o,
   output logic [PPN_W-1:0]            ppn_o
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = valid_i[w] && (tag_i[w] == key_i);
   end

   // At most one way matches: refills overwrite a present tag in place
   always_comb begin
      ppn_o = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) ppn_o = ppn_o | ppn_i[w];
      end
   end

   assign hit_o = |match;

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
   import tlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int TAG_W = 6,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]             valid_i,
   input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
   input  logic [TAG_W-1:0]            key_i,
   input  logic [WAY_W-1:0]            ptr_i,
   output logic [WAY_W-1:0]            way_o,
   output victim_src_e                 src_o
);

   logic [WAYS-1:0]  same;
   logic [WAY_W-1:0] same_way;
   logic [WAY_W-1:0] free_way;

   for (genvar w = 0; w < WAYS; w++) begin : g_same
      assign same[w] = valid_i[w] && (tag_i[w] == key_i);
   end

   // Lowest index wins in both searches
   always_comb begin
      same_way = '0;
      free_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (same[w])     same_way = WAY_W'(w);
         if (!valid_i[w]) free_way = WAY_W'(w);
      end
   end

   always_comb begin
      if (|same) begin
         way_o = same_way;
         src_o = VICT_MATCH;
      end else if (!(&valid_i)) begin
         way_o = free_way;
         src_o = VICT_FREE;
      end else begin
         way_o = ptr_i;
         src_o = VICT_ROTATE;
      end
   end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int TAG_W = 6,
   parameter int PPN_W = 6,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  flush_i,
   input  logic                                  we_i,
   input  logic [IDX_W-1:0]                      set_i,
   input  logic [WAY_W-1:0]                      way_i,
   input  logic [TAG_W-1:0]                      tag_i,
   input  logic [PPN_W-1:0]                      ppn_i,
   output logic [SETS-1:0][WAYS-1:0]             valid_o,
   output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_o,
   output logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_o
);

   logic [SETS-1:0][WAYS-1:0]             valid_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
   logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         tag_q   <= '0;
         ppn_q   <= '0;
      end else if (flush_i) begin
         valid_q <= '0;
      end else if (we_i) begin
         valid_q[set_i][way_i] <= 1'b1;
         tag_q[set_i][way_i]   <= tag_i;
         ppn_q[set_i][way_i]   <= ppn_i;
      end
   end

   assign valid_o = valid_q;
   assign tag_o   = tag_q;
   assign ppn_o   = ppn_q;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int VA_W  = 14,
   parameter int PA_W  = 12,
   parameter int OFF_W = 6,
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   localparam int VPN_W = VA_W - OFF_W,
   localparam int PPN_W = PA_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic             fill_i,
   input  logic [VPN_W-1:0] fill_vpn_i,
   input  logic [PPN_W-1:0] fill_ppn_i,
   input  logic             flush_i,
   output logic             rsp_valid_o,
   output logic             hit_o,
   output logic             miss_o,
   output logic [PA_W-1:0]  pa_o
);

   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = VPN_W - IDX_W;

   // Elaboration-time parameter checks
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (PPN_W < 1 || TAG_W < 1) begin : g_bad_widths
      $error("address widths leave no page number or tag bits");
   end

   // Address fields
   logic [IDX_W-1:0] req_set, fill_set;
   logic [TAG_W-1:0] req_tag, fill_tag;

   assign req_set  = va_i[OFF_W +: IDX_W];
   assign req_tag  = va_i[VA_W-1 -: TAG_W];
   assign fill_set = fill_vpn_i[IDX_W-1:0];
   assign fill_tag = fill_vpn_i[VPN_W-1 -: TAG_W];

   // Storage
   logic [SETS-1:0][WAYS-1:0]             st_valid;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  st_tag;
   logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  st_ppn;

   logic             fill_go;
   logic [WAY_W-1:0] vic_way;
   victim_src_e      vic_src;

   assign fill_go = fill_i && !flush_i;

   tlb_entry_store #(
      .SETS (SETS),
      .WAYS (WAYS),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush_i(flush_i),
      .we_i   (fill_go),
      .set_i  (fill_set),
      .way_i  (vic_way),
      .tag_i  (fill_tag),
      .ppn_i  (fill_ppn_i),
      .valid_o(st_valid),
      .tag_o  (st_tag),
      .ppn_o  (st_ppn)
   );

   // Per-set round-robin pointers
   logic [SETS-1:0][WAY_W-1:0] rr_q;

   for (genvar s = 0; s < SETS; s++) begin : g_rr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rr_q[s] <= '0;
         end else if (flush_i) begin
            rr_q[s] <= '0;
         end else if (fill_go && fill_set == IDX_W'(s) && vic_src == VICT_ROTATE) begin
            rr_q[s] <= rr_q[s] + 1'b1;
         end
      end
   end

   tlb_victim_sel #(
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) u_victim (
      .valid_i(st_valid[fill_set]),
      .tag_i  (st_tag[fill_set]),
      .key_i  (fill_tag),
      .ptr_i  (rr_q[fill_set]),
      .way_o  (vic_way),
      .src_o  (vic_src)
   );

   // Lookup view of the indexed set, with a same-set refill forwarded
   logic [WAYS-1:0]             view_valid;
   logic [WAYS-1:0][TAG_W-1:0]  view_tag;
   logic [WAYS-1:0][PPN_W-1:0]  view_ppn;
   logic                        fwd_en;

   assign fwd_en = fill_go && (fill_set == req_set);

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         if (fwd_en && vic_way == WAY_W'(w)) begin
            view_valid[w] = 1'b1;
            view_tag[w]   = fill_tag;
            view_ppn[w]   = fill_ppn_i;
         end else begin
            view_valid[w] = st_valid[req_set][w];
            view_tag[w]   = st_tag[req_set][w];
            view_ppn[w]   = st_ppn[req_set][w];
         end
      end
   end

   logic             look_hit;
   logic [PPN_W-1:0] look_ppn;

   tlb_way_cmp #(
      .WAYS (WAYS),
      .TAG_W(TAG_W),
      .PPN_W(PPN_W)
   ) u_cmp (
      .valid_i(view_valid),
      .tag_i  (view_tag),
      .ppn_i  (view_ppn),
      .key_i  (req_tag),
      .hit_o  (look_hit),
      .ppn_o  (look_ppn)
   );

   // Registered response
   logic            hit_c;
   logic            rsp_q, hit_q, miss_q;
   logic [PA_W-1:0] pa_q;

   assign hit_c = look_hit && !flush_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_q  <= 1'b0;
         hit_q  <= 1'b0;
         miss_q <= 1'b0;
         pa_q   <= '0;
      end else begin
         rsp_q  <= req_i;
         hit_q  <= req_i && hit_c;
         miss_q <= req_i && !hit_c;
         if (req_i) begin
            pa_q <= {(hit_c ? look_ppn : {PPN_W{1'b0}}), va_i[OFF_W-1:0]};
         end else begin
            pa_q <= '0;
         end
      end
   end

   assign rsp_valid_o = rsp_q;
   assign hit_o       = hit_q;
   assign miss_o      = miss_q;
   assign pa_o        = pa_q;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
   parameter int PA_W  = 12,
   parameter int OFF_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic [OFF_W-1:0] va_off_i,
   input logic             flush_i,
   input logic             rsp_valid_o,
   input logic             hit_o,
   input logic             miss_o,
   input logic [PA_W-1:0]  pa_o
);

   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> pa_o[OFF_W-1:0] == $past(va_off_i));

   p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> rsp_valid_o);

   p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (!rsp_valid_o && !hit_o && !miss_o && pa_o == '0));

   p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> (hit_o ^ miss_o));

   p_miss_no_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      miss_o |-> pa_o[PA_W-1:OFF_W] == '0);

   p_flush_lookup_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && flush_i) |=> miss_o);

   // R4: outputs held low while reset is asserted
   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_quiet_r4: assert (!rsp_valid_o && !hit_o && !miss_o && pa_o == '0);
      end
   end

endmodule

bind tlb_xlate tlb_xlate_chk #(
   .PA_W (PA_W),
   .OFF_W(OFF_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .va_off_i   (va_i[OFF_W-1:0]),
   .flush_i    (flush_i),
   .rsp_valid_o(rsp_valid_o),
   .hit_o      (hit_o),
   .miss_o     (miss_o),
   .pa_o       (pa_o)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [13:0] va_i = '0;
   logic        fill_i = 1'b0;
   logic [7:0]  fill_vpn_i = '0;
   logic [5:0]  fill_ppn_i = '0;
   logic        flush_i = 1'b0;
   logic        rsp_valid_o, hit_o, miss_o;
   logic [11:0] pa_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tlb_xlate dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .va_i       (va_i),
      .fill_i     (fill_i),
      .fill_vpn_i (fill_vpn_i),
      .fill_ppn_i (fill_ppn_i),
      .flush_i    (flush_i),
      .rsp_valid_o(rsp_valid_o),
      .hit_o      (hit_o),
      .miss_o     (miss_o),
      .pa_o       (pa_o)
   );

   // {va[13:0], expect_hit, expect_pa[11:0]}
   localparam int NV = 7;
   localparam logic [26:0] VEC [NV] = '{
      {14'h03D4, 1'b1, 12'h354},
      {14'h0020, 1'b1, 12'hA20},
      {14'h0D7F, 1'b1, 12'hB7F},
      {14'h3FFF, 1'b1, 12'hFFF},
      {14'h04C5, 1'b0, 12'h005},
      {14'h13EA, 1'b0, 12'h02A},
      {14'h0041, 1'b0, 12'h001}
   };

   task automatic check(input bit ok, input string rq, input logic [14:0] act, input logic [14:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // Response word: {valid, hit, miss, pa}
   task automatic lookup(input logic [13:0] va, input bit exp_hit, input logic [11:0] exp_pa, input string rq);
      logic [14:0] exp;
      @(negedge clk);
      req_i = 1'b1;
      va_i  = va;
      @(negedge clk);
      req_i = 1'b0;
      exp = {1'b1, exp_hit, !exp_hit, exp_pa};
      check({rsp_valid_o, hit_o, miss_o, pa_o} == exp, rq, {rsp_valid_o, hit_o, miss_o, pa_o}, exp);
   endtask

   task automatic refill(input logic [7:0] vpn, input logic [5:0] ppn);
      @(negedge clk);
      fill_i = 1'b1;
      fill_vpn_i = vpn;
      fill_ppn_i = ppn;
      @(negedge clk);
      fill_i = 1'b0;
   endtask

   task automatic flush();
      @(negedge clk);
      flush_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
   endtask

   function automatic logic [13:0] va_of(input logic [7:0] vpn, input logic [5:0] off);
      return {vpn, off};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R4: quiet during reset
      check({rsp_valid_o, hit_o, miss_o, pa_o} == '0, "R4 reset outputs",
            {rsp_valid_o, hit_o, miss_o, pa_o}, '0);
      rst_n = 1'b1;
      // R4: empty after reset
      lookup(14'h03D4, 1'b0, 12'h014, "R4 first lookup misses");

      // R6 / R2 / R1: table walk
      refill(8'h0F, 6'h0D);
      refill(8'h00, 6'h28);
      refill(8'h35, 6'h2D);
      refill(8'hFF, 6'h3F);
      for (int i = 0; i < NV; i++) begin
         lookup(VEC[i][26:13], VEC[i][12], VEC[i][11:0], "R2 R6 R1 vector");
      end

      // R3: idle cycle leaves outputs zero
      @(negedge clk);
      @(negedge clk);
      check({rsp_valid_o, hit_o, miss_o, pa_o} == '0, "R3 idle",
            {rsp_valid_o, hit_o, miss_o, pa_o}, '0);

      // R5: flush empties everything
      flush();
      lookup(14'h03D4, 1'b0, 12'h014, "R5 miss after flush");
      lookup(14'h3FFF, 1'b0, 12'h03F, "R5 miss after flush");

      // R10 setup: one entry in set 3
      refill(8'h0F, 6'h0D);
      // R7: four free ways in set 0, then a fifth replaces way 0
      refill(8'h04, 6'h01);
      refill(8'h08, 6'h02);
      refill(8'h0C, 6'h03);
      refill(8'h10, 6'h04);
      lookup(va_of(8'h04, 6'h00), 1'b1, {6'h01, 6'h00}, "R7 full set way0");
      lookup(va_of(8'h10, 6'h11), 1'b1, {6'h04, 6'h11}, "R7 full set way3");
      refill(8'h14, 6'h05);
      lookup(va_of(8'h04, 6'h00), 1'b0, {6'h00, 6'h00}, "R7 oldest evicted");
      lookup(va_of(8'h14, 6'h02), 1'b1, {6'h05, 6'h02}, "R7 new entry");
      lookup(va_of(8'h08, 6'h03), 1'b1, {6'h02, 6'h03}, "R7 others kept");
      // R8: overwrite in place, pointer stays at way 1
      refill(8'h0C, 6'h22);
      lookup(va_of(8'h0C, 6'h04), 1'b1, {6'h22, 6'h04}, "R8 overwrite new ppn");
      lookup(va_of(8'h08, 6'h05), 1'b1, {6'h02, 6'h05}, "R8 no eviction");
      refill(8'h18, 6'h06);
      lookup(va_of(8'h08, 6'h06), 1'b0, {6'h00, 6'h06}, "R8 R7 pointer way1 evicted");
      lookup(va_of(8'h0C, 6'h07), 1'b1, {6'h22, 6'h07}, "R8 overwritten way kept");
      lookup(va_of(8'h18, 6'h08), 1'b1, {6'h06, 6'h08}, "R7 pointer victim filled");
      // R10: set 3 untouched by set 0 traffic
      lookup(14'h03D4, 1'b1, 12'h354, "R10 other set intact");

      // R9: same-cycle refill and lookup to one set
      @(negedge clk);
      fill_i = 1'b1; fill_vpn_i = 8'h21; fill_ppn_i = 6'h11;
      req_i = 1'b1;  va_i = 14'h0847;
      @(negedge clk);
      fill_i = 1'b0; req_i = 1'b0;
      check({rsp_valid_o, hit_o, miss_o, pa_o} == {3'b110, 12'h447}, "R9 forwarded refill",
            {rsp_valid_o, hit_o, miss_o, pa_o}, {3'b110, 12'h447});

      // R5: lookup during flush misses
      @(negedge clk);
      flush_i = 1'b1; req_i = 1'b1; va_i = 14'h03D4;
      @(negedge clk);
      flush_i = 1'b0; req_i = 1'b0;
      check({rsp_valid_o, hit_o, miss_o, pa_o} == {3'b101, 12'h014}, "R5 lookup during flush",
            {rsp_valid_o, hit_o, miss_o, pa_o}, {3'b101, 12'h014});
      // R5: refill during flush dropped
      @(negedge clk);
      flush_i = 1'b1; fill_i = 1'b1; fill_vpn_i = 8'h0F; fill_ppn_i = 6'h0D;
      @(negedge clk);
      flush_i = 1'b0; fill_i = 1'b0;
      lookup(14'h03D4, 1'b0, 12'h014, "R5 refill during flush dropped");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule